// File: doc/BRIEF.md
# Indexed Configuration Port with Write Key

This block is a small byte-wide configuration space that a host reaches through two strobed ports. A write on the index port picks one register of the space; a write on the data port stores a byte into the picked register, and the read data output always shows the picked register's value. Most writable registers are guarded by a key register. Until the open key is written there, every write to a guarded register is dropped.

The space holds the device's 16-bit base address, an interrupt enable byte, a logical-device activate flag, two 16-bit I/O bases (one for data, one for commands), and an interrupt number and type. It also holds fixed identification bytes that cannot be written: a one-byte signature, four text bytes and a four-byte version. A build-time option models an absent device, in which case the first version byte reads 0xFF. The decoded base addresses and enables leave the block as plain outputs.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the space is locked (`cfg_open`=0), the index is 0x00, and `dev_base`, `data_io_base`, `cmd_io_base`, `irq_number`, `irq_kind`, `irq_enable` and `dev_active` are all zero.
- R2: A pulse on `idx_we` loads `wdata` into the index register. `rdata` shows the register at the current index, with no cycle of delay after that register changes.
- R3: A data write of 0x55 while the index is 0x0D opens the space, and a data write of 0xAA at index 0x0D locks it. Reading index 0x0D returns 0x01 when open and 0x00 when locked.
- R4: A data write at index 0x0D of any value other than 0x55 or 0xAA leaves the lock state unchanged.
- R5: While the space is locked, data writes to the guarded registers (0x08, 0x09, 0x0A, 0x30, 0x60 to 0x63, 0x70, 0x71) are ignored. Reads are allowed at all times.
- R6: When open, index 0x08 holds the low byte and index 0x09 the high byte of `dev_base`.
- R7: Index 0x0A stores a byte and reads it back. `irq_enable` is 1 exactly when that byte is nonzero, so writing 0x00 disables interrupts.
- R8: Index 0x30 keeps only bit 0 of a write, and reads back with bits 7 to 1 as zero. `dev_active` equals that bit.
- R9: Index 0x20 reads 0xEF. Indices 0x04 to 0x07 read the text bytes 0x41, 0x54, 0x4D, 0x4C. Indices 0x00 to 0x03 read the version bytes, most significant first. Writes to these indices have no effect, even when the space is open.
- R10: When the device is built as absent, index 0x00 reads 0xFF and the other version bytes are unchanged.
- R11: `data_io_base` takes its high byte from 0x60 and its low byte from 0x61. `cmd_io_base` takes its high byte from 0x62 and its low byte from 0x63. `irq_number` comes from 0x70 and `irq_kind` from 0x71.
- R12: Any index with no register behind it reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_we | input | 1 | Index port write strobe |
| dat_we | input | 1 | Data port write strobe |
| wdata | input | 8 | Write byte shared by both ports |
| rdata | output | 8 | Value of the register at the current index |
| cfg_open | output | 1 | Space is open for writes to guarded registers |
| dev_base | output | 16 | Device base address |
| irq_enable | output | 1 | Interrupt enable byte is nonzero |
| dev_active | output | 1 | Logical device activated |
| data_io_base | output | 16 | Data I/O base address |
| cmd_io_base | output | 16 | Command I/O base address |
| irq_number | output | 8 | Interrupt number |
| irq_kind | output | 8 | Interrupt type byte |

## Verification
A wrong lock state is the most damaging internal error, because it affects every later write. It shows up one cycle after the next guarded write: the decoded outputs either change when they should not, or fail to change when they should. It also appears at once on `rdata` at index 0x0D. A slot-decode error sends a byte to the wrong output, or the stored byte disappears. Because `rdata` is combinational, any stored register can be read back on the cycle after its write. The bench therefore compares every output after every random operation against its own model.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam logic [7:0] IX_KEY     = 8'h0D;
   localparam logic [7:0] IX_SIG     = 8'h20;
   localparam logic [7:0] KEY_OPEN   = 8'h55;
   localparam logic [7:0] KEY_SHUT   = 8'hAA;
   localparam int         NSLOT      = 10;
   localparam int         SLOT_W     = $clog2(NSLOT);
   localparam int         SLOT_ACT   = 3;

   typedef struct packed {
      logic              hit;
      logic [SLOT_W-1:0] slot;
   } slot_sel_t;

   // maps a guarded register index onto a storage slot
   function automatic slot_sel_t slot_of(input logic [7:0] ix);
      slot_sel_t s;
      s.hit  = 1'b1;
      s.slot = '0;
      case (ix)
         8'h08: s.slot = SLOT_W'(0);
         8'h09: s.slot = SLOT_W'(1);
         8'h0A: s.slot = SLOT_W'(2);
         8'h30: s.slot = SLOT_W'(SLOT_ACT);
         8'h60: s.slot = SLOT_W'(4);
         8'h61: s.slot = SLOT_W'(5);
         8'h62: s.slot = SLOT_W'(6);
         8'h63: s.slot = SLOT_W'(7);
         8'h70: s.slot = SLOT_W'(8);
         8'h71: s.slot = SLOT_W'(9);
         default: s.hit = 1'b0;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/cfgp_lock.sv
module cfgp_lock
   import cfgp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_we_i,
   input  logic [7:0] wdata_i,
   output logic       open_o
);
   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               open_q <= 1'b0;
      else if (key_we_i && wdata_i == KEY_OPEN) open_q <= 1'b1;
      else if (key_we_i && wdata_i == KEY_SHUT) open_q <= 1'b0;
   end

   assign open_o = open_q;

   AST_KEY_OTHER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      key_we_i && wdata_i != KEY_OPEN && wdata_i != KEY_SHUT |=> $stable(open_o)); // R4
   AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(key_we_i) && $past(wdata_i) == KEY_OPEN); // R3
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
   import cfgp_pkg::*;
#(
   parameter logic [15:0] BASE_RST = 16'h0000
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic                 open_i,
   input  slot_sel_t            sel_i,
   input  logic [7:0]           wdata_i,
   output logic [NSLOT*8-1:0]   slots_o
);
   logic [NSLOT*8-1:0] slots_q;

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam logic [7:0] RST_V = (g == 0) ? BASE_RST[7:0] :
                                     (g == 1) ? BASE_RST[15:8] : 8'h00;
      logic hit_w;
      assign hit_w = we_i && open_i && sel_i.hit && sel_i.slot == SLOT_W'(g);
      if (g == SLOT_ACT) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slots_q[g*8 +: 8] <= 8'h00;
            else if (hit_w) slots_q[g*8 +: 8] <= {7'b0, wdata_i[0]};
         end
      end else begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     slots_q[g*8 +: 8] <= RST_V;
            else if (hit_w) slots_q[g*8 +: 8] <= wdata_i;
         end
      end
   end

   assign slots_o = slots_q;

   AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && !open_i |=> $stable(slots_o)); // R5
   AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && !sel_i.hit |=> $stable(slots_o)); // R12
endmodule

// File: rtl/cfgp_ident.sv
module cfgp_ident #(
   parameter logic [31:0] VERSION  = 32'h01020304,
   parameter logic [31:0] TEXT_ID  = 32'h41544D4C,
   parameter logic [7:0]  SIG_BYTE = 8'hEF,
   parameter bit          PRESENT  = 1'b1
)(
   input  logic [7:0] idx_i,
   output logic       hit_o,
   output logic [7:0] byte_o
);
   logic [7:0] ver0;

   if (PRESENT) begin : g_present
      if (VERSION[31:24] == 8'hFF) begin : g_bad
         $error("first version byte 0xFF would mark the device absent");
      end
      assign ver0 = VERSION[31:24];
   end else begin : g_absent
      assign ver0 = 8'hFF;
   end

   always_comb begin
      hit_o  = 1'b1;
      byte_o = 8'h00;
      case (idx_i)
         8'h00: byte_o = ver0;
         8'h01: byte_o = VERSION[23:16];
         8'h02: byte_o = VERSION[15:8];
         8'h03: byte_o = VERSION[7:0];
         8'h04: byte_o = TEXT_ID[31:24];
         8'h05: byte_o = TEXT_ID[23:16];
         8'h06: byte_o = TEXT_ID[15:8];
         8'h07: byte_o = TEXT_ID[7:0];
         8'h20: byte_o = SIG_BYTE;
         default: hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfgp_pkg::*;
#(
   parameter logic [31:0] VERSION  = 32'h01020304,
   parameter logic [31:0] TEXT_ID  = 32'h41544D4C,
   parameter logic [7:0]  SIG_BYTE = 8'hEF,
   parameter bit          PRESENT  = 1'b1,
   parameter logic [15:0] BASE_RST = 16'h0000
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        idx_we,
   input  logic        dat_we,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   output logic        cfg_open,
   output logic [15:0] dev_base,
   output logic        irq_enable,
   output logic        dev_active,
   output logic [15:0] data_io_base,
   output logic [15:0] cmd_io_base,
   output logic [7:0]  irq_number,
   output logic [7:0]  irq_kind
);
   logic [7:0]         idx_q;
   logic [NSLOT*8-1:0] slots;
   slot_sel_t          sel;
   logic               id_hit;
   logic [7:0]         id_byte;
   logic               open_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= 8'h00;
      else if (idx_we) idx_q <= wdata;
   end

   assign sel = slot_of(idx_q);

   cfgp_lock u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we_i (dat_we && idx_q == IX_KEY),
      .wdata_i  (wdata),
      .open_o   (open_w)
   );

   cfgp_regfile #(.BASE_RST(BASE_RST)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (dat_we),
      .open_i  (open_w),
      .sel_i   (sel),
      .wdata_i (wdata),
      .slots_o (slots)
   );

   cfgp_ident #(
      .VERSION (VERSION),
      .TEXT_ID (TEXT_ID),
      .SIG_BYTE(SIG_BYTE),
      .PRESENT (PRESENT)
   ) u_ident (
      .idx_i  (idx_q),
      .hit_o  (id_hit),
      .byte_o (id_byte)
   );

   always_comb begin
      if (idx_q == IX_KEY) rdata = {7'b0, open_w};
      else if (sel.hit)    rdata = slots[sel.slot*8 +: 8];
      else if (id_hit)     rdata = id_byte;
      else                 rdata = 8'h00;
   end

   assign cfg_open     = open_w;
   assign dev_base     = {slots[15:8], slots[7:0]};
   assign irq_enable   = |slots[23:16];
   assign dev_active   = slots[SLOT_ACT*8];
   assign data_io_base = {slots[39:32], slots[47:40]};
   assign cmd_io_base  = {slots[55:48], slots[63:56]};
   assign irq_number   = slots[71:64];
   assign irq_kind     = slots[79:72];

   AST_ACT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q == 8'h30 |-> rdata[7:1] == 7'b0); // R8
   AST_SIG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q == IX_SIG |-> rdata == SIG_BYTE); // R9
   AST_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |=> $stable(dev_base)); // R5
endmodule

// File: tb/test_cfg_index_port.sv
`timescale 1ns/1ps
module test_cfg_index_port;
   localparam logic [31:0] VER = 32'h01020304;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        idx_we = 1'b0, dat_we = 1'b0;
   logic [7:0]  wdata = 8'h00;
   logic [7:0]  rdata, rdata_ab;
   logic        cfg_open, irq_enable, dev_active;
   logic [15:0] dev_base, data_io_base, cmd_io_base;
   logic [7:0]  irq_number, irq_kind;
   logic        ab_open, ab_irq, ab_act;
   logic [15:0] ab_base, ab_dio, ab_cio;
   logic [7:0]  ab_num, ab_kind;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [7:0] m [256];
   bit unl;

   always #2.5 clk = ~clk;

   cfg_index_port #(.VERSION(VER)) i_cfg_index_port (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata),
      .rdata(rdata), .cfg_open(cfg_open), .dev_base(dev_base), .irq_enable(irq_enable),
      .dev_active(dev_active), .data_io_base(data_io_base), .cmd_io_base(cmd_io_base),
      .irq_number(irq_number), .irq_kind(irq_kind));

   cfg_index_port #(.VERSION(VER), .PRESENT(1'b0)) i_cfg_index_port_absent (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata),
      .rdata(rdata_ab), .cfg_open(ab_open), .dev_base(ab_base), .irq_enable(ab_irq),
      .dev_active(ab_act), .data_io_base(ab_dio), .cmd_io_base(ab_cio),
      .irq_number(ab_num), .irq_kind(ab_kind));

   function automatic bit guarded(input logic [7:0] ix);
      return ix inside {8'h08, 8'h09, 8'h0A, 8'h30, 8'h60, 8'h61, 8'h62, 8'h63, 8'h70, 8'h71};
   endfunction

   function automatic logic [7:0] exp_read(input logic [7:0] ix);
      if (ix == 8'h0D)   return {7'b0, unl};
      if (guarded(ix))   return m[ix];
      if (ix == 8'h20)   return 8'hEF;
      if (ix <= 8'h03)   return VER[31 - 8*ix -: 8];
      if (ix <= 8'h07)   return (ix == 8'h04) ? 8'h41 : (ix == 8'h05) ? 8'h54 :
                                (ix == 8'h06) ? 8'h4D : 8'h4C;
      return 8'h00;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_idx(input logic [7:0] v);
      @(negedge clk); idx_we = 1'b1; wdata = v;
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic pulse_dat(input logic [7:0] v);
      @(negedge clk); dat_we = 1'b1; wdata = v;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] ix, input logic [7:0] v);
      pulse_idx(ix);
      pulse_dat(v);
      if (ix == 8'h0D) begin
         if (v == 8'h55) unl = 1;
         else if (v == 8'hAA) unl = 0;
      end else if (guarded(ix) && unl) begin
         m[ix] = (ix == 8'h30) ? {7'b0, v[0]} : v;
      end
   endtask

   task automatic do_read(input logic [7:0] ix, input string req);
      pulse_idx(ix);
      #1;
      check(rdata === exp_read(ix), req, rdata, exp_read(ix));
   endtask

   task automatic check_outs();
      check(cfg_open === unl, "R3 cfg_open", cfg_open, unl);
      check(dev_base === {m[8'h09], m[8'h08]}, "R6 dev_base", dev_base, {m[8'h09], m[8'h08]});
      check(irq_enable === (m[8'h0A] != 0), "R7 irq_enable", irq_enable, m[8'h0A] != 0);
      check(dev_active === m[8'h30][0], "R8 dev_active", dev_active, m[8'h30][0]);
      check(data_io_base === {m[8'h60], m[8'h61]}, "R11 data_io_base", data_io_base, {m[8'h60], m[8'h61]});
      check(cmd_io_base === {m[8'h62], m[8'h63]}, "R11 cmd_io_base", cmd_io_base, {m[8'h62], m[8'h63]});
      check(irq_number === m[8'h70], "R11 irq_number", irq_number, m[8'h70]);
      check(irq_kind === m[8'h71], "R11 irq_kind", irq_kind, m[8'h71]);
   endtask

   function automatic logic [7:0] pick_idx();
      case ($urandom % 16)
         0: return 8'h08;  1: return 8'h09;  2: return 8'h0A;  3: return 8'h30;
         4: return 8'h60;  5: return 8'h61;  6: return 8'h62;  7: return 8'h63;
         8: return 8'h70;  9: return 8'h71;  10: return 8'h0D; 11: return 8'h0D;
         12: return 8'h20; 13: return 8'($urandom % 8);
         default: return 8'($urandom);
      endcase
   endfunction

   function automatic logic [7:0] pick_val(input logic [7:0] ix);
      int r = $urandom % 10;
      if (ix == 8'h0D && r < 4) return 8'h55;
      if (ix == 8'h0D && r < 7) return 8'hAA;
      if (r == 9) return 8'h00;
      return 8'($urandom);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20241));
      foreach (m[i]) m[i] = 8'h00;
      unl = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check(cfg_open === 1'b0, "R1 locked after reset", cfg_open, 0);
      check(rdata === VER[31:24], "R1 index zero after reset", rdata, VER[31:24]);
      check({dev_base, data_io_base, cmd_io_base, irq_number, irq_kind, irq_enable, dev_active} === '0,
            "R1 outputs zero", dev_base, 0);
      // R5 locked write ignored
      do_write(8'h08, 8'h3C); #1;
      check(dev_base === 16'h0000, "R5 locked write dropped", dev_base, 0);
      do_read(8'h08, "R5 readback while locked");
      // R4 stray key value
      do_write(8'h0D, 8'h12); #1;
      check(cfg_open === 1'b0, "R4 stray key keeps lock", cfg_open, 0);
      // R3 open
      do_write(8'h0D, 8'h55);
      do_read(8'h0D, "R3 key reads open");
      do_write(8'h0D, 8'h7E); #1;
      check(cfg_open === 1'b1, "R4 stray key keeps open", cfg_open, 1);
      // R6 base
      do_write(8'h08, 8'h60); do_write(8'h09, 8'h03); #1;
      check(dev_base === 16'h0360, "R6 base address", dev_base, 16'h0360);
      // R7 irq enable
      do_write(8'h0A, 8'h07); #1;
      check(irq_enable === 1'b1, "R7 irq on", irq_enable, 1);
      do_write(8'h0A, 8'h00); #1;
      check(irq_enable === 1'b0, "R7 irq off", irq_enable, 0);
      // R8 activate
      do_write(8'h30, 8'hFF);
      do_read(8'h30, "R8 only bit0 kept");
      check(dev_active === 1'b1, "R8 active", dev_active, 1);
      // R9 identification, write ignored while open
      do_write(8'h20, 8'h00);
      do_read(8'h20, "R9 signature");
      do_write(8'h04, 8'h00);
      for (int i = 0; i < 8; i++) do_read(8'(i), "R9 id bytes");
      // R10 absent variant
      pulse_idx(8'h00); #1;
      check(rdata_ab === 8'hFF, "R10 absent marker", rdata_ab, 8'hFF);
      pulse_idx(8'h01); #1;
      check(rdata_ab === VER[23:16], "R10 absent version byte1", rdata_ab, VER[23:16]);
      // R11 io bases and irq
      do_write(8'h60, 8'h03); do_write(8'h61, 8'h60);
      do_write(8'h62, 8'h03); do_write(8'h63, 8'h61);
      do_write(8'h70, 8'h07); do_write(8'h71, 8'h02); #1;
      check(data_io_base === 16'h0360, "R11 data base", data_io_base, 16'h0360);
      check(cmd_io_base === 16'h0361, "R11 cmd base", cmd_io_base, 16'h0361);
      // R12 unmapped
      do_write(8'h45, 8'h99);
      do_read(8'h45, "R12 unmapped reads zero");
      // R3 relock then R5
      do_write(8'h0D, 8'hAA);
      do_read(8'h0D, "R3 key reads locked");
      do_write(8'h70, 8'h0B); #1;
      check(irq_number === 8'h07, "R5 relocked write dropped", irq_number, 8'h07);
      check_outs();
      // R2 random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] ix;
         ix = pick_idx();
         if ($urandom % 3 == 0) do_read(ix, "R2 random read");
         else begin
            do_write(ix, pick_val(ix));
            #1;
            check(rdata === exp_read(ix), "R2 readback after write", rdata, exp_read(ix));
            check_outs();
         end
      end
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule